// File: doc/BRIEF.md
# Audio Sample FIFO and Interrupt Controller

This block sits between a register bus and a serial audio transceiver core. It buffers samples in four channel queues: left and right for transmit, and left and right for receive. Software loads transmit samples and drains receive samples through the bus. The transceiver pops transmit samples and pushes receive samples through single-cycle strobes.

A control word is changed only through a set address and a clear address. It holds the direction enables, two queue flush bits and two per-direction interrupt enables. Fill levels and thresholds are packed two 8-bit fields to a word.

Four sticky event flags record:
- threshold crossings in each direction;
- receive overflow;
- transmit underflow.

Each flag can be masked and is cleared by writing ones. A single interrupt line combines the flags that are unmasked and whose direction interrupt is enabled.

Top module: `aud_fifo_irq`

## Requirements
- R1: Writing address 1 ORs data bits 5:0 into the control word and writing address 2 clears the bits set in the data. Address 0 reads the control word back. Bit 0 is transmit enable (drives `tx_en_o`) and bit 1 is receive enable (drives `rx_en_o`).
- R2: A bus write to address 4 (left) or 5 (right) queues a transmit sample on that channel. `tx_valid_o[c]` is high while channel c (0 left, 1 right) holds data, and its output shows the oldest sample. A `tx_pop_i[c]` strobe with transmit enabled advances to the next sample in order.
- R3: A bus write to a full transmit queue is ignored: the level stays at DEPTH and the stored samples are unchanged.
- R4: A `rx_push_i[c]` strobe with receive enabled queues that channel's input sample. A bus read of address 4 (left) or 5 (right) returns the oldest receive sample and removes it. Reading an empty queue returns 0.
- R5: Address 6 reads the transmit levels and address 7 the receive levels, left in bits 7:0 and right in bits 15:8.
- R6: Address 3 holds the transmit threshold in bits 7:0 and the receive threshold in bits 15:8. Both reset to 8.
- R7: Status bit 0 sets while receive is enabled and either receive level is at or above the receive threshold. Status bit 1 sets while transmit is enabled and either transmit level is at or below the transmit threshold.
- R8: A receive push into a full queue with receive enabled drops the sample and sets status bit 2. A transmit pop from an empty queue with transmit enabled sets status bit 3.
- R9: Address 8 reads the 4-bit status. Writing ones there clears those bits, unless their condition is still present in that cycle.
- R10: Address 9 holds a 4-bit mask. `irq_o` is high when any status bit is set, unmasked, and enabled by its direction's interrupt enable. Control bit 4 enables status bits 1 and 3; control bit 5 enables status bits 0 and 2.
- R11: While control bit 2 is set, both transmit queues are held empty and ignore writes. Control bit 3 does the same for the receive queues. Flushing leaves the status bits unchanged.
- R12: After reset the control word, levels, status and mask read 0, no transmit data is valid and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Bus write strobe |
| reg_re_i | input | 1 | Bus read strobe (pops receive queues) |
| reg_addr_i | input | 4 | Bus word address |
| reg_wdata_i | input | 32 | Bus write data |
| reg_rdata_o | output | 32 | Bus read data |
| tx_en_o | output | 1 | Transmit enable to transceiver |
| rx_en_o | output | 1 | Receive enable to transceiver |
| tx_pop_i | input | 2 | Transmit sample taken, per channel |
| tx_valid_o | output | 2 | Transmit sample available, per channel |
| tx_left_o | output | DW | Oldest left transmit sample |
| tx_right_o | output | DW | Oldest right transmit sample |
| rx_push_i | input | 2 | Receive sample strobe, per channel |
| rx_left_i | input | DW | Left receive sample |
| rx_right_i | input | DW | Right receive sample |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with a queue depth of 6 and 16-bit samples. With that depth, a few bus writes or push strobes fill a queue, so the ignored write and the dropped push can be reached quickly. Thresholds of 2 and 3 sit inside the 0..6 level range, so both threshold flags can be driven on and off. The small depth also makes the pointer wrap in the pop sequence.

// File: rtl/aud_fifo_pkg.sv
`timescale 1ns/1ps
package aud_fifo_pkg;
  typedef enum logic [3:0] {
    A_CTRL = 4'd0,
    A_CSET = 4'd1,
    A_CCLR = 4'd2,
    A_THR  = 4'd3,
    A_SMPL = 4'd4,
    A_SMPR = 4'd5,
    A_TXLV = 4'd6,
    A_RXLV = 4'd7,
    A_ISTA = 4'd8,
    A_IMSK = 4'd9
  } aud_addr_e;

  localparam int CTL_W    = 6;
  localparam int CTL_TXEN = 0;
  localparam int CTL_RXEN = 1;
  localparam int CTL_TXFL = 2;
  localparam int CTL_RXFL = 3;
  localparam int CTL_TXIE = 4;
  localparam int CTL_RXIE = 5;

  localparam int NSRC     = 4;
  localparam int IS_RXTH  = 0;
  localparam int IS_TXTH  = 1;
  localparam int IS_RXOV  = 2;
  localparam int IS_TXUN  = 3;
endpackage

// File: rtl/aud_chan_fifo.sv
`timescale 1ns/1ps
module aud_chan_fifo #(
  parameter int DW    = 24,
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                data_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign data_o  = empty_o ? '0 : mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));
  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(level_o));
  // R11
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0));
endmodule

// File: rtl/aud_irq_ctrl.sv
`timescale 1ns/1ps
module aud_irq_ctrl #(
  parameter int NS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  input  logic [NS-1:0] mask_i,
  input  logic [NS-1:0] en_i,
  output logic [NS-1:0] stat_o,
  output logic          irq_o
);
  logic [NS-1:0] stat_q;

  // a live condition outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_i & en_i);

  // R9
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((stat_o & $past(clr_i & ~set_i)) == '0));
  // R7
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));
  // R10
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o);
endmodule

// File: rtl/aud_fifo_irq.sv
`timescale 1ns/1ps
module aud_fifo_irq
  import aud_fifo_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 16,
  parameter int CW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          tx_en_o,
  output logic          rx_en_o,
  input  logic [1:0]    tx_pop_i,
  output logic [1:0]    tx_valid_o,
  output logic [DW-1:0] tx_left_o,
  output logic [DW-1:0] tx_right_o,
  input  logic [1:0]    rx_push_i,
  input  logic [DW-1:0] rx_left_i,
  input  logic [DW-1:0] rx_right_i,
  output logic          irq_o
);
  localparam int LW = $clog2(DEPTH+1);

  logic [CTL_W-1:0] ctrl_q;
  logic [CW-1:0]    tx_thr_q, rx_thr_q;
  logic [NSRC-1:0]  mask_q, stat, set_v, clr_v, en_v;
  logic             tx_en, rx_en, tx_fl, rx_fl;

  logic [DW-1:0]    tx_dat [2];
  logic [DW-1:0]    rx_dat [2];
  logic [LW-1:0]    tx_lvl_raw [2];
  logic [LW-1:0]    rx_lvl_raw [2];
  logic [CW-1:0]    tx_lvl [2];
  logic [CW-1:0]    rx_lvl [2];
  logic [1:0]       tx_full, tx_empty, rx_full, rx_empty;

  assign tx_en = ctrl_q[CTL_TXEN];
  assign rx_en = ctrl_q[CTL_RXEN];
  assign tx_fl = ctrl_q[CTL_TXFL];
  assign rx_fl = ctrl_q[CTL_RXFL];
  assign tx_en_o = tx_en;
  assign rx_en_o = rx_en;

  function automatic logic wr_at(input aud_addr_e a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      tx_thr_q <= CW'(8);
      rx_thr_q <= CW'(8);
      mask_q   <= '0;
    end else begin
      if (wr_at(A_CSET))      ctrl_q <= ctrl_q | reg_wdata_i[CTL_W-1:0];
      else if (wr_at(A_CCLR)) ctrl_q <= ctrl_q & ~reg_wdata_i[CTL_W-1:0];
      if (wr_at(A_THR)) begin
        tx_thr_q <= reg_wdata_i[CW-1:0];
        rx_thr_q <= reg_wdata_i[2*CW-1:CW];
      end
      if (wr_at(A_IMSK)) mask_q <= reg_wdata_i[NSRC-1:0];
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam aud_addr_e SA = (c == 0) ? A_SMPL : A_SMPR;

    aud_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (tx_fl),
      .push_i  (wr_at(SA)),
      .data_i  (reg_wdata_i[DW-1:0]),
      .pop_i   (tx_pop_i[c] & tx_en),
      .data_o  (tx_dat[c]),
      .level_o (tx_lvl_raw[c]),
      .full_o  (tx_full[c]),
      .empty_o (tx_empty[c])
    );

    aud_chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (rx_fl),
      .push_i  (rx_push_i[c] & rx_en),
      .data_i  ((c == 0) ? rx_left_i : rx_right_i),
      .pop_i   (reg_re_i && (reg_addr_i == SA)),
      .data_o  (rx_dat[c]),
      .level_o (rx_lvl_raw[c]),
      .full_o  (rx_full[c]),
      .empty_o (rx_empty[c])
    );

    assign tx_lvl[c] = CW'(tx_lvl_raw[c]);
    assign rx_lvl[c] = CW'(rx_lvl_raw[c]);
  end

  if (DW < 32) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^reg_wdata_i[31:DW];
  end
  logic unused_flags;
  assign unused_flags = ^{tx_full, rx_empty};

  assign tx_valid_o = ~tx_empty;
  assign tx_left_o  = tx_dat[0];
  assign tx_right_o = tx_dat[1];

  always_comb begin
    set_v = '0;
    set_v[IS_RXTH] = rx_en & ((rx_lvl[0] >= rx_thr_q) | (rx_lvl[1] >= rx_thr_q));
    set_v[IS_TXTH] = tx_en & ((tx_lvl[0] <= tx_thr_q) | (tx_lvl[1] <= tx_thr_q));
    set_v[IS_RXOV] = rx_en & ~rx_fl & |(rx_push_i & rx_full);
    set_v[IS_TXUN] = tx_en & ~tx_fl & |(tx_pop_i & tx_empty);
    en_v = '0;
    en_v[IS_RXTH] = ctrl_q[CTL_RXIE];
    en_v[IS_RXOV] = ctrl_q[CTL_RXIE];
    en_v[IS_TXTH] = ctrl_q[CTL_TXIE];
    en_v[IS_TXUN] = ctrl_q[CTL_TXIE];
  end

  assign clr_v = wr_at(A_ISTA) ? reg_wdata_i[NSRC-1:0] : '0;

  aud_irq_ctrl #(.NS(NSRC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .mask_i (mask_q),
    .en_i   (en_v),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: reg_rdata_o[CTL_W-1:0]  = ctrl_q;
      A_THR:  reg_rdata_o[2*CW-1:0]   = {rx_thr_q, tx_thr_q};
      A_SMPL: reg_rdata_o[DW-1:0]     = rx_dat[0];
      A_SMPR: reg_rdata_o[DW-1:0]     = rx_dat[1];
      A_TXLV: reg_rdata_o[2*CW-1:0]   = {tx_lvl[1], tx_lvl[0]};
      A_RXLV: reg_rdata_o[2*CW-1:0]   = {rx_lvl[1], rx_lvl[0]};
      A_ISTA: reg_rdata_o[NSRC-1:0]   = stat;
      A_IMSK: reg_rdata_o[NSRC-1:0]   = mask_q;
      default: reg_rdata_o = '0;
    endcase
  end

  // R1
  ctrl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CSET) |=>
      ((ctrl_q & $past(reg_wdata_i[CTL_W-1:0])) == $past(reg_wdata_i[CTL_W-1:0])));
  // R1
  ctrl_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CCLR) |=>
      ((ctrl_q & $past(reg_wdata_i[CTL_W-1:0])) == '0));
  // R8
  rx_ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en && !rx_fl && rx_push_i[0] && rx_full[0]) |=> stat[IS_RXOV]);
endmodule

// File: tb/aud_fifo_irq_test.sv
`timescale 1ns/1ps
module aud_fifo_irq_test;
  localparam int DW = 16;
  localparam int DEPTH = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          tx_en, rx_en, irq;
  logic [1:0]    tx_pop = '0, tx_valid, rx_push = '0;
  logic [DW-1:0] tx_left, tx_right;
  logic [DW-1:0] rx_left = '0, rx_right = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  aud_fifo_irq #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_en_o(tx_en), .rx_en_o(rx_en),
    .tx_pop_i(tx_pop), .tx_valid_o(tx_valid),
    .tx_left_o(tx_left), .tx_right_o(tx_right),
    .rx_push_i(rx_push), .rx_left_i(rx_left), .rx_right_i(rx_right),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic pop_tx(input int c);
    @(negedge clk); tx_pop[c] = 1'b1;
    @(negedge clk); tx_pop = '0;
  endtask

  task automatic push_rx(input int c, input logic [DW-1:0] d);
    @(negedge clk); rx_push[c] = 1'b1;
    if (c == 0) rx_left = d; else rx_right = d;
    @(negedge clk); rx_push = '0;
  endtask

  // op: 0 write, 1 read and compare, 2 idle (data = cycles)
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'h1, 32'h03,   32'h0,    8'd1},  // R1 set both enables
    '{2'd1, 4'h0, 32'h0,    32'h03,   8'd1},  // R1
    '{2'd0, 4'h2, 32'h01,   32'h0,    8'd1},  // R1 clear tx enable
    '{2'd1, 4'h0, 32'h0,    32'h02,   8'd1},  // R1
    '{2'd0, 4'h3, 32'h0302, 32'h0,    8'd6},  // R6 tx 2, rx 3
    '{2'd1, 4'h3, 32'h0,    32'h0302, 8'd6},  // R6
    '{2'd0, 4'h4, 32'h1111, 32'h0,    8'd2},  // R2
    '{2'd0, 4'h4, 32'h2222, 32'h0,    8'd2},  // R2
    '{2'd0, 4'h5, 32'h3333, 32'h0,    8'd2},  // R2
    '{2'd1, 4'h6, 32'h0,    32'h0102, 8'd5},  // R5
    '{2'd0, 4'h8, 32'h0F,   32'h0,    8'd9},  // R9 clear all
    '{2'd1, 4'h8, 32'h0,    32'h0,    8'd9},  // R9
    '{2'd0, 4'h1, 32'h01,   32'h0,    8'd7},  // R7 tx enable
    '{2'd2, 4'h0, 32'd2,    32'h0,    8'd7},
    '{2'd1, 4'h8, 32'h0,    32'h02,   8'd7},  // R7 right level 1 <= 2
    '{2'd0, 4'h8, 32'h02,   32'h0,    8'd9},  // R9 clear while live
    '{2'd1, 4'h8, 32'h0,    32'h02,   8'd9},  // R9
    '{2'd0, 4'h5, 32'h4444, 32'h0,    8'd2},
    '{2'd0, 4'h5, 32'h5555, 32'h0,    8'd2},
    '{2'd0, 4'h4, 32'h6666, 32'h0,    8'd2},
    '{2'd1, 4'h6, 32'h0,    32'h0303, 8'd5},  // R5
    '{2'd0, 4'h8, 32'h02,   32'h0,    8'd9},  // R9 no live condition
    '{2'd2, 4'h0, 32'd2,    32'h0,    8'd9},
    '{2'd1, 4'h8, 32'h0,    32'h00,   8'd9}   // R9
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 reset state
    #1;
    chk("R12 irq", {31'd0, irq}, 32'h0);
    chk("R12 valid", {30'd0, tx_valid}, 32'h0);
    bus_rd(4'h0, rd); chk("R12 ctrl", rd, 32'h0);
    bus_rd(4'h3, rd); chk("R12 thr", rd, 32'h0808);
    bus_rd(4'h6, rd); chk("R12 txlv", rd, 32'h0);
    bus_rd(4'h7, rd); chk("R12 rxlv", rd, 32'h0);
    bus_rd(4'h8, rd); chk("R12 stat", rd, 32'h0);
    bus_rd(4'h9, rd); chk("R12 mask", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: bus_wr(VEC[i].addr, VEC[i].data);
        2'd1: begin
          bus_rd(VEC[i].addr, rd);
          chk($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].exp);
        end
        default: repeat (VEC[i].data) @(negedge clk);
      endcase
    end

    // R1 enables at the pins
    #1 chk("R1 pins", {30'd0, rx_en, tx_en}, 32'h3);

    // R2 ordered output: left 1111,2222,6666 right 3333,4444,5555
    chk("R2 valid", {30'd0, tx_valid}, 32'h3);
    chk("R2 left", {16'd0, tx_left}, 32'h1111);
    chk("R2 right", {16'd0, tx_right}, 32'h3333);
    pop_tx(0); #1 chk("R2 left2", {16'd0, tx_left}, 32'h2222);
    pop_tx(0); #1 chk("R2 left3", {16'd0, tx_left}, 32'h6666);
    pop_tx(0); #1 chk("R2 empty", {30'd0, tx_valid}, 32'h2);

    // R8 underflow
    pop_tx(0);
    repeat (2) @(negedge clk);
    bus_rd(4'h8, rd); chk("R8 underflow", rd, 32'h0A);

    // R10 interrupt gating
    #1 chk("R10 no ie", {31'd0, irq}, 32'h0);
    bus_wr(4'h1, 32'h10); #1 chk("R10 tx ie", {31'd0, irq}, 32'h1);
    bus_wr(4'h9, 32'h0A); #1 chk("R10 masked", {31'd0, irq}, 32'h0);
    bus_wr(4'h9, 32'h08); #1 chk("R10 part mask", {31'd0, irq}, 32'h1);
    bus_wr(4'h9, 32'h00);

    // R3 full transmit queue ignores writes
    bus_wr(4'h5, 32'hA001);
    bus_wr(4'h5, 32'hA002);
    bus_wr(4'h5, 32'hA003);
    bus_wr(4'h5, 32'h7777);
    bus_rd(4'h6, rd); chk("R3 full level", rd, 32'h0600);
    for (int k = 0; k < 5; k++) pop_tx(1);
    #1 chk("R3 last kept", {16'd0, tx_right}, 32'hA003);
    bus_rd(4'h6, rd); chk("R3 level1", rd, 32'h0100);
    pop_tx(1);
    #1 chk("R3 drained", {30'd0, tx_valid}, 32'h0);

    // R4 receive path
    push_rx(0, 16'hB001);
    push_rx(0, 16'hB002);
    push_rx(1, 16'hC001);
    bus_rd(4'h7, rd); chk("R4 rxlv", rd, 32'h0102);
    bus_rd(4'h4, rd); chk("R4 first", rd, 32'hB001);
    bus_rd(4'h4, rd); chk("R4 second", rd, 32'hB002);
    bus_rd(4'h4, rd); chk("R4 empty read", rd, 32'h0);
    bus_rd(4'h5, rd); chk("R4 right", rd, 32'hC001);

    // R7 receive threshold
    bus_rd(4'h8, rd); chk("R7 rx below", rd & 32'h1, 32'h0);
    push_rx(0, 16'hD001);
    push_rx(0, 16'hD002);
    push_rx(0, 16'hD003);
    repeat (2) @(negedge clk);
    bus_rd(4'h8, rd); chk("R7 rx reached", rd & 32'h1, 32'h1);

    // R8 overflow drops the sample
    push_rx(0, 16'hD004);
    push_rx(0, 16'hD005);
    push_rx(0, 16'hD006);
    push_rx(0, 16'hDEAD);
    bus_rd(4'h8, rd); chk("R8 overflow", rd & 32'h4, 32'h4);
    bus_rd(4'h7, rd); chk("R8 level", rd, 32'h0006);
    bus_rd(4'h4, rd); chk("R8 oldest", rd, 32'hD001);

    // R11 flushes
    bus_wr(4'h1, 32'h08);
    bus_rd(4'h7, rd); chk("R11 rx flushed", rd, 32'h0);
    push_rx(0, 16'hE001);
    bus_rd(4'h7, rd); chk("R11 push ignored", rd, 32'h0);
    bus_rd(4'h8, rd); chk("R11 stat kept", rd & 32'h4, 32'h4);
    bus_wr(4'h2, 32'h08);
    bus_rd(4'h4, rd); chk("R11 rx empty", rd, 32'h0);
    bus_wr(4'h4, 32'hF001);
    bus_rd(4'h6, rd); chk("R11 tx before", rd, 32'h0001);
    bus_wr(4'h1, 32'h04);
    bus_rd(4'h6, rd); chk("R11 tx flushed", rd, 32'h0);
    bus_wr(4'h4, 32'hF002);
    bus_rd(4'h6, rd); chk("R11 tx write ignored", rd, 32'h0);
    bus_wr(4'h2, 32'h04);

    // R9 clear of non-live bits
    bus_wr(4'h8, 32'h05);
    bus_rd(4'h8, rd); chk("R9 cleared", rd & 32'h5, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule